// File: doc/BRIEF.md
# UART Register Control Core

This block is the register-side half of a UART. A host reaches it through a single-cycle register strobe with byte-wide data and a 6-bit offset, so addresses are decoded modulo 64. Behind that window sit:

- two mode bytes, reached through a pointer that moves forward on its own;
- a status byte and an interrupt status byte;
- an interrupt mask and two fixed divider bytes;
- a one-byte transmit holding register;
- a small receive queue, four entries deep by default.

A write-only command byte carries three independent fields: a miscellaneous action, a transmitter control and a receiver control.

The serial side is not part of this block. Received bytes arrive on a byte input that is qualified by a valid and gated by an accept output. A break indication arrives on its own input. Outgoing bytes leave on a byte output with a one-cycle valid strobe. A level interrupt output is high whenever any unmasked interrupt status bit is set.

Top module: `uart_ctl_core`

## Requirements
- R1: Offsets are 6 bits wide. 0x18 and 0x1C read the two divider constants (parameters DIV_A and DIV_B). A write to the status offset 0x04 changes nothing. Every other offset not named in R2 to R4 or R8 reads 0. `bus_rdata` is 0 in any cycle without a read strobe.
- R2: A write to 0x00 stores the byte into the mode register selected by the pointer, then points the pointer at the second mode register. A read of 0x00 returns the selected register. Only miscellaneous command 1 moves the pointer back to the first register.
- R3: The status byte at 0x04 has these bits, with bits 7..4 reading 0:
  - bit0: receive queue not empty;
  - bit1: receive queue full;
  - bit2: transmitter enabled (ready);
  - bit3: transmit holding register empty.
- R4: The interrupt status byte, read at 0x14, has these bits, with the rest reading 0:
  - bit0: equals status bit2;
  - bit1: equals status bit1 when bit 6 of the first mode register is 1, and status bit0 otherwise;
  - bit2: break-seen flag.
  A write to 0x14 sets the mask. `irq` is high exactly when (interrupt status AND mask) is nonzero.
- R5: The command byte is written at 0x08. Its fields are applied in the order miscellaneous, then transmitter, then receiver.
  - Bits [6:4] (miscellaneous): 1 resets the pointer; 2 disables the receiver and empties the queue; 3 disables the transmitter and marks it empty, discarding any held byte; 5 clears the break-seen flag; 0, 4, 6 and 7 do nothing.
  - Bits [3:2] (transmitter) and bits [1:0] (receiver): 1 enables, 2 disables, 3 is ignored.
- R6: When the transmitter is enabled, a write to 0x0C sends the byte: `tx_valid` is high for exactly one cycle, the cycle after the write, with the byte on `tx_data`. Status bit3 stays set.
- R7: When the transmitter is disabled, a write to 0x0C keeps the byte and clears status bit3. A later transmitter-enable command sends the held byte in the cycle after that command.
- R8: `rx_accept` is high exactly when the receiver is enabled and the queue is not full. A byte offered while `rx_accept` is high is appended to the queue. A read of 0x0C returns the oldest byte and removes it. A read of 0x0C with an empty queue returns 0 and leaves the queue unchanged.
- R9: A break pulse sets the break-seen flag and pushes a zero byte, whether or not the receiver is enabled. If the queue is full, the zero replaces the newest entry. A data byte offered in the same cycle as a break is dropped.
- R10: Within one cycle, the register access is applied before the receive event. A pop and a push in the same cycle remove the oldest byte and append the new one. A receiver-reset command plus a push in the same cycle leaves only the new byte.
- R11: After reset the status reads 0x08. Both mode registers, the mask and the interrupt status read 0. Both enables are off and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | DW | Receive byte |
| rx_break | input | 1 | Break event pulse |
| rx_accept | output | 1 | Receive side can take a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | DW | Transmit byte |

## Verification
Two functions can coincide in one cycle: a host read of the receive data offset, which pops the queue, and a receive event, which pushes a byte or a break zero. A reset-receiver command can also meet a push in the same cycle. Directed cycles drive each of these pairs together on purpose. Random traffic also drives them together, with the byte and break inputs raised independently of the register strobe. The outcome is judged against a bench model that applies the register access first and the receive event second. Order and count are then confirmed through the data bytes read back afterwards and through the status bits.

// File: rtl/uart_ctl_pkg.sv
`timescale 1ns/1ps
package uart_ctl_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_INT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_DIVA = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DIVB = 6'h1C;

    // status bit positions
    localparam int ST_RXRDY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMP = 3;

    // interrupt status bit positions
    localparam int IS_TX  = 0;
    localparam int IS_RX  = 1;
    localparam int IS_BRK = 2;

    // first mode register: receive interrupt source select
    localparam int MODE_RXSEL = 6;

    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_op_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
`timescale 1ns/1ps
module uart_cmd_decode
    import uart_ctl_pkg::*;
(
    input  logic       strobe,
    input  logic [6:0] cmd,
    output cmd_act_t   act
);

    misc_op_e misc;

    always_comb begin
        misc = misc_op_e'(cmd[6:4]);
        act  = '0;
        if (strobe) begin
            case (misc)
                MISC_PTR_RST: act.ptr_rst = 1'b1;
                MISC_RX_RST:  act.rx_rst  = 1'b1;
                MISC_TX_RST:  act.tx_rst  = 1'b1;
                MISC_BRK_CLR: act.brk_clr = 1'b1;
                default:      ;
            endcase
            case (cmd[3:2])
                2'd1:    act.tx_on  = 1'b1;
                2'd2:    act.tx_off = 1'b1;
                default: ;
            endcase
            case (cmd[1:0])
                2'd1:    act.rx_on  = 1'b1;
                2'd2:    act.rx_off = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_queue.sv
`timescale 1ns/1ps
module uart_rx_queue #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          pop,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slot;
        logic [CW-1:0]            cnt;
    } rxq_t;

    rxq_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d.cnt = '0;
        end
        if (pop && q_d.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                q_d.slot[i] = q_d.slot[i+1];
            end
            q_d.cnt = q_d.cnt - 1'b1;
        end
        if (push) begin
            if (q_d.cnt == FULL_CNT) begin
                q_d.slot[DEPTH-1] = push_data;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == q_d.cnt) begin
                        q_d.slot[i] = push_data;
                    end
                end
                q_d.cnt = q_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head  = q_q.slot[0];
    assign count = q_q.cnt;

endmodule

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          rst_tx,
    input  logic          en_on,
    input  logic          en_off,
    output logic          tx_en,
    output logic          tx_empty,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data
);

    typedef struct packed {
        logic          en;
        logic          empty;
        logic [DW-1:0] hold;
        logic          v;
        logic [DW-1:0] d;
    } txh_t;

    txh_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        s_d.v = 1'b0;
        if (rst_tx) begin
            s_d.en    = 1'b0;
            s_d.empty = 1'b1;
        end
        if (en_on) begin
            s_d.en = 1'b1;
            if (!s_d.empty) begin
                s_d.v     = 1'b1;
                s_d.d     = s_d.hold;
                s_d.empty = 1'b1;
            end
        end
        if (en_off) begin
            s_d.en = 1'b0;
        end
        if (load) begin
            s_d.hold  = load_data;
            s_d.empty = 1'b0;
            if (s_d.en) begin
                s_d.v     = 1'b1;
                s_d.d     = load_data;
                s_d.empty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_en    = s_q.en;
    assign tx_empty = s_q.empty;
    assign tx_valid = s_q.v;
    assign tx_data  = s_q.d;

endmodule

// File: rtl/uart_ctl_core.sv
`timescale 1ns/1ps
module uart_ctl_core
    import uart_ctl_pkg::*;
#(
    parameter int            RX_DEPTH = 4,
    parameter int            DW       = 8,
    parameter logic [DW-1:0] DIV_A    = '0,
    parameter logic [DW-1:0] DIV_B    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              rx_break,
    output logic              rx_accept,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_data
);

    localparam int            CNT_W    = $clog2(RX_DEPTH + 1);
    localparam logic [CNT_W-1:0] Q_FULL = CNT_W'(RX_DEPTH);

    typedef struct packed {
        logic [DW-1:0] mode1;
        logic [DW-1:0] mode2;
        logic          ptr;
        logic          rx_en;
        logic          brk;
        logic [DW-1:0] imr;
    } core_t;

    core_t core_d, core_q;

    logic             rd_stb, wr_stb;
    cmd_act_t         act;
    logic [CNT_W-1:0] rxq_count;
    logic [DW-1:0]    rxq_head;
    logic             rxq_push;
    logic [DW-1:0]    rxq_push_data;
    logic             tx_en, tx_empty;
    logic [DW-1:0]    stat_v, isr_v;
    logic             mode_ptr_q;

    assign rd_stb = bus_valid && !bus_write;
    assign wr_stb = bus_valid && bus_write;

    uart_cmd_decode u_cmd (
        .strobe (wr_stb && bus_addr == OFS_CMD),
        .cmd    (bus_wdata[6:0]),
        .act    (act)
    );

    assign rx_accept     = core_q.rx_en && (rxq_count != Q_FULL);
    assign rxq_push      = rx_break || (rx_valid && rx_accept);
    assign rxq_push_data = rx_break ? '0 : rx_data;

    uart_rx_queue #(
        .DEPTH (RX_DEPTH),
        .DW    (DW),
        .CW    (CNT_W)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (act.rx_rst),
        .pop       (rd_stb && bus_addr == OFS_DATA),
        .push      (rxq_push),
        .push_data (rxq_push_data),
        .head      (rxq_head),
        .count     (rxq_count)
    );

    uart_tx_hold #(
        .DW (DW)
    ) u_txh (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_stb && bus_addr == OFS_DATA),
        .load_data (bus_wdata),
        .rst_tx    (act.tx_rst),
        .en_on     (act.tx_on),
        .en_off    (act.tx_off),
        .tx_en     (tx_en),
        .tx_empty  (tx_empty),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    // status and interrupt status views
    always_comb begin
        stat_v           = '0;
        stat_v[ST_RXRDY] = (rxq_count != '0);
        stat_v[ST_FULL]  = (rxq_count == Q_FULL);
        stat_v[ST_TXRDY] = tx_en;
        stat_v[ST_TXEMP] = tx_empty;
        isr_v            = '0;
        isr_v[IS_TX]     = stat_v[ST_TXRDY];
        isr_v[IS_RX]     = core_q.mode1[MODE_RXSEL] ? stat_v[ST_FULL] : stat_v[ST_RXRDY];
        isr_v[IS_BRK]    = core_q.brk;
    end

    assign irq = |(isr_v & core_q.imr);

    // next state: register access first, receive event second
    always_comb begin
        core_d = core_q;
        if (wr_stb && bus_addr == OFS_MODE) begin
            if (core_q.ptr) begin
                core_d.mode2 = bus_wdata;
            end else begin
                core_d.mode1 = bus_wdata;
            end
            core_d.ptr = 1'b1;
        end
        if (act.ptr_rst) core_d.ptr   = 1'b0;
        if (act.rx_rst)  core_d.rx_en = 1'b0;
        if (act.brk_clr) core_d.brk   = 1'b0;
        if (act.rx_on)   core_d.rx_en = 1'b1;
        if (act.rx_off)  core_d.rx_en = 1'b0;
        if (wr_stb && bus_addr == OFS_INT) begin
            core_d.imr = bus_wdata;
        end
        if (rx_break) begin
            core_d.brk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    // read data mux
    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            case (bus_addr)
                OFS_MODE: bus_rdata = core_q.ptr ? core_q.mode2 : core_q.mode1;
                OFS_STAT: bus_rdata = stat_v;
                OFS_DATA: bus_rdata = (rxq_count != '0) ? rxq_head : '0;
                OFS_INT:  bus_rdata = isr_v;
                OFS_DIVA: bus_rdata = DIV_A;
                OFS_DIVB: bus_rdata = DIV_B;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign mode_ptr_q = core_q.ptr;

endmodule

// File: rtl/uart_ctl_core_chk.sv
`timescale 1ns/1ps
module uart_ctl_core_chk
    import uart_ctl_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int CW    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              irq,
    input logic              rx_accept,
    input logic              tx_valid,
    input logic [CW-1:0]     rxq_count,
    input logic              mode_ptr_q
);

    // R8: accept only with room left
    p_accept_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> (rxq_count < CW'(DEPTH)));

    // R8: queue never overfills
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_count <= CW'(DEPTH));

    // R8: empty read yields zero
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == OFS_DATA && rxq_count == '0)
        |-> (bus_rdata == '0));

    // R6: a transmit strobe follows a data or command write
    p_tx_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_valid && bus_write &&
                           (bus_addr == OFS_DATA || bus_addr == OFS_CMD)));

    // R2: pointer moves to the second mode register after a mode write
    p_ptr_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_MODE) |=> mode_ptr_q);

    // R4: a zero mask silences the interrupt
    p_mask_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_INT && bus_wdata == '0) |=> !irq);

    // R1: read data is zero without a read strobe
    p_rdata_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |-> (bus_rdata == '0));

endmodule

bind uart_ctl_core uart_ctl_core_chk #(
    .DEPTH (RX_DEPTH),
    .DW    (DW),
    .CW    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .rx_accept  (rx_accept),
    .tx_valid   (tx_valid),
    .rxq_count  (rxq_count),
    .mode_ptr_q (mode_ptr_q)
);

// File: tb/uart_ctl_core_tb.sv
`timescale 1ns/1ps
module uart_ctl_core_tb;

    localparam logic [7:0] DA = 8'h3C;
    localparam logic [7:0] DB = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq, rx_accept, tx_valid;
    logic       rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0] rx_data = '0, tx_data;

    always #2.5 clk = ~clk;

    uart_ctl_core #(.RX_DEPTH(4), .DW(8), .DIV_A(DA), .DIV_B(DB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .rx_accept(rx_accept), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_fifo[4];
    int         m_cnt;
    logic [7:0] m_mr[2];
    int         m_ptr;
    bit         m_rxen, m_txen, m_txemp, m_db;
    logic [7:0] m_hold, m_imr;
    bit         e_txv;
    logic [7:0] e_txd;
    logic [7:0] last_rd;
    bit         last_txv;
    logic [7:0] last_txd;

    task automatic model_reset();
        m_cnt = 0; m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0;
        m_rxen = 0; m_txen = 0; m_txemp = 1; m_db = 0;
        m_hold = 0; m_imr = 0; e_txv = 0; e_txd = 0;
    endtask

    function automatic logic [7:0] exp_status();
        return {4'b0, m_txemp, m_txen, m_cnt == 4, m_cnt != 0};
    endfunction

    function automatic logic [7:0] exp_isr();
        bit rxi = m_mr[0][6] ? (m_cnt == 4) : (m_cnt != 0);
        return {5'b0, m_db, rxi, m_txen};
    endfunction

    function automatic logic [7:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return m_mr[m_ptr];
            6'h04: return exp_status();
            6'h0C: return (m_cnt != 0) ? m_fifo[0] : 8'h00;
            6'h14: return exp_isr();
            6'h18: return DA;
            6'h1C: return DB;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_for(input logic [5:0] a);
        case (a)
            6'h00: return "R2";
            6'h04: return "R3";
            6'h0C: return "R8";
            6'h14: return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic m_push(input logic [7:0] x);
        if (m_cnt == 4) m_fifo[3] = x;
        else begin m_fifo[m_cnt] = x; m_cnt++; end
    endtask

    task automatic m_cmd(input logic [7:0] d);
        case (d[6:4])
            3'd1: m_ptr = 0;
            3'd2: begin m_rxen = 0; m_cnt = 0; end
            3'd3: begin m_txen = 0; m_txemp = 1; end
            3'd5: m_db = 0;
            default: ;
        endcase
        case (d[3:2])
            2'd1: begin
                m_txen = 1;
                if (!m_txemp) begin e_txv = 1; e_txd = m_hold; m_txemp = 1; end
            end
            2'd2: m_txen = 0;
            default: ;
        endcase
        case (d[1:0])
            2'd1: m_rxen = 1;
            2'd2: m_rxen = 0;
            default: ;
        endcase
    endtask

    task automatic model_step(input bit v, input bit w, input logic [5:0] a, input logic [7:0] d,
                              input bit rv, input logic [7:0] rd, input bit bk);
        bit acc = m_rxen && (m_cnt < 4);
        e_txv = 0;
        if (v && w) begin
            case (a)
                6'h00: begin m_mr[m_ptr] = d; m_ptr = 1; end
                6'h08: m_cmd(d);
                6'h0C: begin
                    m_txemp = 0; m_hold = d;
                    if (m_txen) begin e_txv = 1; e_txd = d; m_txemp = 1; end
                end
                6'h14: m_imr = d;
                default: ;
            endcase
        end
        if (v && !w && a == 6'h0C && m_cnt > 0) begin
            for (int i = 0; i < 3; i++) m_fifo[i] = m_fifo[i+1];
            m_cnt--;
        end
        if (bk) begin m_db = 1; m_push(8'h00); end
        else if (rv && acc) m_push(rd);
    endtask

    task automatic do_cyc(input bit v, input bit w, input logic [5:0] a, input logic [7:0] d,
                          input bit rv, input logic [7:0] rd, input bit bk);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_data = rd; rx_break = bk;
        #1;
        check(irq === (|(exp_isr() & m_imr)), "R4", {7'b0, irq}, {7'b0, |(exp_isr() & m_imr)});
        check(rx_accept === (m_rxen && m_cnt < 4), "R8", {7'b0, rx_accept}, {7'b0, m_rxen && m_cnt < 4});
        check(tx_valid === e_txv, "R6", {7'b0, tx_valid}, {7'b0, e_txv});
        if (e_txv) check(tx_data === e_txd, "R6", tx_data, e_txd);
        last_txv = tx_valid; last_txd = tx_data;
        if (v && !w) begin
            last_rd = bus_rdata;
            check(bus_rdata === exp_read(a), tag_for(a), bus_rdata, exp_read(a));
        end else begin
            check(bus_rdata === 8'h00, "R1", bus_rdata, 8'h00);
        end
        model_step(v, w, a, d, rv, rd, bk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d); do_cyc(1, 1, a, d, 0, 0, 0); endtask
    task automatic rd(input logic [5:0] a); do_cyc(1, 0, a, 0, 0, 0, 0); endtask
    task automatic idle(); do_cyc(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rxb(input logic [7:0] x); do_cyc(0, 0, 0, 0, 1, x, 0); endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11 / R3 / R1: reset view and address map
        rd(6'h04); expect_eq("R11", last_rd, 8'h08);
        rd(6'h00); expect_eq("R11", last_rd, 8'h00);
        rd(6'h14); expect_eq("R11", last_rd, 8'h00);
        rd(6'h18); expect_eq("R1", last_rd, DA);
        rd(6'h1C); expect_eq("R1", last_rd, DB);
        rd(6'h10); expect_eq("R1", last_rd, 8'h00);
        wr(6'h04, 8'hFF); rd(6'h04); expect_eq("R1", last_rd, 8'h08);

        // R2: mode pointer
        wr(6'h00, 8'h11); wr(6'h00, 8'h22);
        rd(6'h00); expect_eq("R2", last_rd, 8'h22);
        wr(6'h08, 8'h10);
        rd(6'h00); expect_eq("R2", last_rd, 8'h11);

        // R7: held byte sent on enable
        wr(6'h0C, 8'h5A);
        rd(6'h04); expect_eq("R7", last_rd, 8'h00);
        wr(6'h08, 8'h04); idle();
        expect_eq("R7", {7'b0, last_txv}, 8'h01); expect_eq("R7", last_txd, 8'h5A);
        rd(6'h04); expect_eq("R3", last_rd, 8'h0C);

        // R6: immediate send
        wr(6'h0C, 8'h77); idle();
        expect_eq("R6", {7'b0, last_txv}, 8'h01); expect_eq("R6", last_txd, 8'h77);

        // R7: reset transmitter discards held byte
        wr(6'h08, 8'h08); wr(6'h0C, 8'h99); wr(6'h08, 8'h30); wr(6'h08, 8'h04); idle();
        expect_eq("R7", {7'b0, last_txv}, 8'h00);

        // R5: reserved fields ignored, ordering misc then tx then rx
        wr(6'h08, 8'h0F);
        rd(6'h04); expect_eq("R5", last_rd, 8'h0C);
        wr(6'h08, 8'h35);
        rd(6'h04); expect_eq("R5", last_rd, 8'h0C);

        // R8 / R9: fill, break overwrite, drain
        rxb(8'h01); rxb(8'h02); rxb(8'h03); rxb(8'h04);
        rd(6'h04); expect_eq("R8", last_rd, 8'h0F);
        do_cyc(0, 0, 0, 0, 0, 0, 1);
        rd(6'h14); expect_eq("R9", last_rd, 8'h07);
        rd(6'h0C); expect_eq("R8", last_rd, 8'h01);
        rd(6'h0C); expect_eq("R8", last_rd, 8'h02);
        rd(6'h0C); expect_eq("R8", last_rd, 8'h03);
        rd(6'h0C); expect_eq("R9", last_rd, 8'h00);
        rd(6'h0C); expect_eq("R8", last_rd, 8'h00);
        rd(6'h04); expect_eq("R8", last_rd, 8'h0C);
        wr(6'h08, 8'h50);
        rd(6'h14); expect_eq("R9", last_rd, 8'h01);

        // R10: pop and push together
        rxb(8'hA1);
        do_cyc(1, 0, 6'h0C, 0, 1, 8'hB2, 0); expect_eq("R10", last_rd, 8'hA1);
        rd(6'h0C); expect_eq("R10", last_rd, 8'hB2);
        // R9: break wins over data in the same cycle
        do_cyc(0, 0, 0, 0, 1, 8'h55, 1);
        rd(6'h0C); expect_eq("R9", last_rd, 8'h00);
        rd(6'h04); expect_eq("R9", last_rd, 8'h0C);
        // R10: receiver reset with a push in the same cycle
        rxb(8'h66);
        do_cyc(1, 1, 6'h08, 8'h20, 1, 8'hC3, 0);
        rd(6'h0C); expect_eq("R10", last_rd, 8'hC3);
        rd(6'h04); expect_eq("R10", last_rd, 8'h0C);

        // R4: receive interrupt sourced from full
        wr(6'h08, 8'h11); wr(6'h00, 8'h40); rxb(8'h10);
        rd(6'h14); expect_eq("R4", last_rd, 8'h05);
        wr(6'h14, 8'h02); idle();
        expect_eq("R4", {7'b0, irq}, 8'h00);

        // random traffic with the model checking every cycle
        for (int n = 0; n < 4000; n++) begin
            int sel = $urandom_range(0, 8);
            logic [5:0] a = (sel == 8) ? 6'($urandom) : 6'(sel * 4);
            bit w = $urandom_range(0, 1);
            logic [7:0] d = 8'($urandom);
            bit v = ($urandom_range(0, 3) != 0);
            if (a == 6'h08) begin
                d[6:4] = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'd0;
                d[1:0] = ($urandom_range(0, 9) < 7) ? 2'd1 : 2'($urandom);
            end
            do_cyc(v, w, a, d, ($urandom_range(0, 9) < 4), 8'($urandom),
                   ($urandom_range(0, 39) == 0));
        end

        finish_up();
    end

endmodule